// File: doc/BRIEF.md
# Page Write Buffer and Address Pointer for a Serial EEPROM

This block sits behind the two-wire protocol engine of a serial EEPROM model. It gathers the data bytes of a write transaction in a one-page staging buffer and keeps the current-address pointer that serves reads. The protocol engine supplies four one-cycle strobes: a word-address load, a received data byte, a commit raised when the stop condition arrives, and a read advance after each byte sent to the host. Bytes are placed at offsets inside one 64-byte page. When the offset runs past the end of the page it returns to the start of the same page. Only a commit copies the staged bytes into the behavioural array.

After a commit the pointer moves by rules that depend on how many bytes were staged. A write-protect input blocks the commit. A busy input, driven by the external write-cycle timer, makes the block ignore every strobe. Read data always shows the array byte at the pointer. The array depth is a parameter. The default is 4K x 8, and setting `ADDR_W` to 14 gives a 16K x 8 part.

Top module: `eeprom_page_stage`

## Requirements
- R1: After reset the pointer output reads 0.
- R2: A load sets the pointer to the low `ADDR_W` bits of the load address and ignores the address bits above them. It also makes that address the start address of the next page write and empties the buffer.
- R3: The k-th byte after a load (k counted from 0) is staged at in-page offset (start offset + k) mod 64, where the in-page offset is the low 6 address bits. The page bits stay those of the start address, and the array does not change before the commit.
- R4: When two staged bytes fall on the same offset, the array receives the later one.
- R5: A commit writes only the offsets that received a byte. Every other array location keeps its value.
- R6: After a commit of n staged bytes with 1 <= n <= 63, the pointer equals page | ((start offset + n) mod 64). When n >= 64, the pointer equals the start address.
- R7: A single byte staged at in-page offset 63 leaves the pointer at offset 0 of the same page after the commit.
- R8: A read advance moves the pointer to pointer + 1. From the last array address it wraps to 0. Read data always equals the array byte at the pointer.
- R9: A commit while write-protect is high changes neither the array nor the pointer, and it empties the buffer.
- R10: While busy is high, load, byte, commit and advance strobes have no effect.
- R11: When strobes coincide, commit wins over load, load over byte, and byte over advance. Each lower strobe in the same cycle is ignored.
- R12: A commit with no staged bytes writes nothing and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Internal write cycle in progress; all strobes are ignored |
| wp_i | input | 1 | Write protect; blocks the commit |
| load_i | input | 1 | Load word address strobe |
| load_addr_i | input | BUS_AW | Word address from the host |
| byte_i | input | 1 | Data byte received strobe |
| byte_data_i | input | DATA_W | Received data byte |
| commit_i | input | 1 | Stop condition after a write transaction |
| adv_i | input | 1 | Advance the pointer after a byte is read |
| rd_data_o | output | DATA_W | Array byte at the pointer |
| ptr_o | output | ADDR_W | Current address pointer |

## Verification
The bench builds the block with `ADDR_W` = 8 and the page width at 6, so the array is four pages of 64 bytes. A bench-side copy of the whole array stays small. The bench sweeps every start offset of a page against byte counts of 1, 2, 5, 63, 64, 65 and 100. That covers partial pages, an exactly full page, wrap-around overwrites and the byte at offset 63. After each case it reads back the whole affected page. The small array also puts the wrap of the pointer from the last address to 0 within a few cycles. The load address is driven with nonzero bits above the array width to show that they are ignored.

// File: rtl/eeprom_page_stage.sv
module eeprom_page_stage #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8,
  parameter int BUS_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              wp_i,
  input  logic              load_i,
  input  logic [BUS_AW-1:0] load_addr_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              commit_i,
  input  logic              adv_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int ROW_W  = ADDR_W - PAGE_W;

  logic [DATA_W-1:0] mem  [DEPTH];
  logic [DATA_W-1:0] pbuf [PAGE_N];
  logic [PAGE_N-1:0] pvld;
  logic [ADDR_W-1:0] ptr, base;
  logic [PAGE_W-1:0] woff;
  logic              full, seen;

  wire unused_hi = ^load_addr_i[BUS_AW-1:ADDR_W];

  wire [ROW_W-1:0]  row      = base[ADDR_W-1:PAGE_W];
  wire [PAGE_W-1:0] base_off = base[PAGE_W-1:0];
  wire [PAGE_W-1:0] woff_nx  = woff + PAGE_W'(1);

  wire do_commit = commit_i & ~busy_i;
  wire do_load   = load_i & ~busy_i & ~commit_i;
  wire do_byte   = byte_i & ~busy_i & ~commit_i & ~load_i;
  wire do_adv    = adv_i & ~busy_i & ~commit_i & ~load_i & ~byte_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      base <= '0;
      woff <= '0;
      full <= 1'b0;
      seen <= 1'b0;
      pvld <= '0;
    end else if (do_commit) begin
      if (!wp_i && seen)
        ptr <= {row, full ? base_off : woff};
      full <= 1'b0;
      seen <= 1'b0;
      pvld <= '0;
    end else if (do_load) begin
      ptr  <= load_addr_i[ADDR_W-1:0];
      base <= load_addr_i[ADDR_W-1:0];
      woff <= load_addr_i[PAGE_W-1:0];
      full <= 1'b0;
      seen <= 1'b0;
      pvld <= '0;
    end else if (do_byte) begin
      pvld[woff] <= 1'b1;
      woff       <= woff_nx;
      seen       <= 1'b1;
      if (woff_nx == base_off)
        full <= 1'b1;
    end else if (do_adv) begin
      ptr <= ptr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_byte)
      pbuf[woff] <= byte_data_i;
  end

  always_ff @(posedge clk) begin
    if (do_commit && !wp_i) begin
      for (int i = 0; i < PAGE_N; i++)
        if (pvld[i])
          mem[{row, PAGE_W'(i)}] <= pbuf[i];
    end
  end

  assign rd_data_o = mem[ptr];
  assign ptr_o     = ptr;
endmodule

module eeprom_page_stage_chk #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 6,
  parameter int BUS_AW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_i,
  input logic              wp_i,
  input logic              load_i,
  input logic [BUS_AW-1:0] load_addr_i,
  input logic              byte_i,
  input logic              commit_i,
  input logic              adv_i,
  input logic [ADDR_W-1:0] ptr_o,
  input logic [ADDR_W-1:0] base,
  input logic              seen
);
  // R2
  load_sets_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy_i && !commit_i) |=> ptr_o == $past(load_addr_i[ADDR_W-1:0]));

  // R8
  adv_increments_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !busy_i && !commit_i && !load_i && !byte_i) |=> ptr_o == $past(ptr_o) + ADDR_W'(1));

  // R9
  wp_holds_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && wp_i && !busy_i) |=> $stable(ptr_o));

  // R10
  busy_freezes_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(ptr_o));

  // R6
  commit_same_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !busy_i && !wp_i && seen) |=> ptr_o[ADDR_W-1:PAGE_W] == $past(base[ADDR_W-1:PAGE_W]));
endmodule

bind eeprom_page_stage eeprom_page_stage_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUS_AW(BUS_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .wp_i(wp_i), .load_i(load_i),
  .load_addr_i(load_addr_i), .byte_i(byte_i), .commit_i(commit_i), .adv_i(adv_i),
  .ptr_o(ptr_o), .base(base), .seen(seen)
);

// File: tb/eeprom_page_stage_test.sv
`timescale 1ns/1ps
module eeprom_page_stage_test;
  localparam int AW = 8, PW = 6, DW = 8, BW = 16;
  localparam int DEPTH = 1 << AW, PN = 1 << PW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, busy_i = 1'b0, wp_i = 1'b0, load_i = 1'b0;
  logic byte_i = 1'b0, commit_i = 1'b0, adv_i = 1'b0;
  logic [BW-1:0] load_addr_i = '0;
  logic [DW-1:0] byte_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [AW-1:0] ptr_o;

  eeprom_page_stage #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .BUS_AW(BW)) uut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .wp_i(wp_i), .load_i(load_i),
    .load_addr_i(load_addr_i), .byte_i(byte_i), .byte_data_i(byte_data_i),
    .commit_i(commit_i), .adv_i(adv_i), .rd_data_o(rd_data_o), .ptr_o(ptr_o)
  );

  int compared = 0, mismatched = 0;
  logic [DW-1:0] mdl [DEPTH];
  logic [DW-1:0] shadow [PN];
  bit sv [PN];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ld(input int a);
    load_i = 1'b1; load_addr_i = BW'(a); step(); load_i = 1'b0;
  endtask

  task automatic put(input int d);
    byte_i = 1'b1; byte_data_i = DW'(d); step(); byte_i = 1'b0;
  endtask

  task automatic cmt();
    commit_i = 1'b1; step(); commit_i = 1'b0;
  endtask

  task automatic adv();
    adv_i = 1'b1; step(); adv_i = 1'b0;
  endtask

  task automatic read_run(input int start, input int n, input string tag);
    int p;
    ld(start);
    p = start % DEPTH;
    for (int k = 0; k < n; k++) begin
      chk(tag, 32'(rd_data_o), 32'(mdl[p]));
      adv();
      p = (p + 1) % DEPTH;
    end
    chk({tag, " pointer after reads"}, 32'(ptr_o), 32'(p));
  endtask

  task automatic trial(input int page, input int so, input int n, input int hi);
    int base, off, d, ep;
    base = page * PN + so;
    for (int i = 0; i < PN; i++) sv[i] = 0;
    ld(base + hi * DEPTH);
    chk("R2 load ignores upper bits", 32'(ptr_o), 32'(base));
    for (int k = 0; k < n; k++) begin
      off = (so + k) % PN;
      d = (page * 31 + so * 5 + k * 11 + n * 3 + hi) & 255;
      shadow[off] = DW'(d);
      sv[off] = 1;
      put(d);
    end
    chk("R3 array untouched before commit", 32'(rd_data_o), 32'(mdl[base]));
    cmt();
    for (int i = 0; i < PN; i++) if (sv[i]) mdl[page * PN + i] = shadow[i];
    ep = page * PN + ((n >= PN) ? so : (so + n) % PN);
    if (so == PN - 1 && n == 1) chk("R7 byte at offset 63 pointer", 32'(ptr_o), 32'(ep));
    else chk("R6 pointer after page commit", 32'(ptr_o), 32'(ep));
    read_run(page * PN, PN, "R3 R4 R5 page contents");
  endtask

  initial begin
    #1900000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int cnts [7];
    cnts = '{1, 2, 5, 63, 64, 65, 100};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1 pointer after reset", 32'(ptr_o), 32'd0);
    cmt();
    chk("R12 empty commit after reset", 32'(ptr_o), 32'd0);

    for (int p = 0; p < DEPTH / PN; p++) trial(p, 0, PN, p);

    for (int so = 0; so < PN; so++)
      for (int c = 0; c < 7; c++)
        trial((so + c) % (DEPTH / PN), so, cnts[c], (so * 7 + c) & 255);

    ld(16'hAB37);
    chk("R2 upper load bits ignored", 32'(ptr_o), 32'h37);

    ld(DEPTH - 1);
    chk("R8 read data at last address", 32'(rd_data_o), 32'(mdl[DEPTH - 1]));
    adv();
    chk("R8 wrap to zero", 32'(ptr_o), 32'd0);
    chk("R8 read data after wrap", 32'(rd_data_o), 32'(mdl[0]));
    read_run(DEPTH - 6, 12, "R8 sequential read across wrap");

    ld(100);
    cmt();
    chk("R12 empty commit keeps pointer", 32'(ptr_o), 32'd100);
    read_run(PN, PN, "R12 page unchanged");

    ld(70);
    put(8'h11); put(8'h22); put(8'h33);
    wp_i = 1'b1;
    cmt();
    wp_i = 1'b0;
    chk("R9 protected commit keeps pointer", 32'(ptr_o), 32'd70);
    cmt();
    chk("R9 buffer emptied by protected commit", 32'(ptr_o), 32'd70);
    read_run(PN, PN, "R9 array unchanged");

    ld(10);
    busy_i = 1'b1;
    ld(200); put(8'hEE); adv(); cmt();
    busy_i = 1'b0;
    chk("R10 busy ignores strobes", 32'(ptr_o), 32'd10);
    cmt();
    chk("R10 no byte accepted while busy", 32'(ptr_o), 32'd10);
    read_run(0, PN, "R10 array unchanged");

    load_i = 1'b1; load_addr_i = 16'd20; adv_i = 1'b1; step();
    load_i = 1'b0; adv_i = 1'b0;
    chk("R11 load beats advance", 32'(ptr_o), 32'd20);
    byte_i = 1'b1; byte_data_i = 8'h5A; adv_i = 1'b1; step();
    byte_i = 1'b0; adv_i = 1'b0;
    chk("R11 byte beats advance", 32'(ptr_o), 32'd20);
    commit_i = 1'b1; load_i = 1'b1; load_addr_i = 16'd150; step();
    commit_i = 1'b0; load_i = 1'b0;
    mdl[20] = 8'h5A;
    chk("R11 commit beats load", 32'(ptr_o), 32'd21);
    read_run(0, PN, "R11 page after coincident strobes");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule